// File: doc/BRIEF.md
# Oversampled serial receiver with byte FIFO

This block is the receive half of an asynchronous serial port. A single serial input line is synchronised into the clock domain and watched for a falling edge. An oversampling tick arrives sixteen times per bit period, and the block uses it to check the start bit at mid-bit, then to sample each data bit once at the centre of its bit period and to check the stop bit. Bits are assembled in an internal 8-bit shift register that the host cannot reach. A run-time input chooses whether the first bit on the line lands in bit 0 or in bit 7.

Each completed character moves into a 16-entry by 8-bit FIFO with no host action, and the shift register can take the next character straight away. The host sees the oldest stored byte on a read-only data output and removes it with a one-cycle read strobe. The block reports occupancy as a count from 0 to 16, plus empty and full. It has two sticky flags: overrun, set when a character is dropped because the FIFO is full, and framing error, set when a stop bit is sampled low. Each flag has its own clear input.

Top module: `serial_rx_fifo`

## Requirements
- R1: After reset, `empty`=1, `full`=0, `level`=0, `overrun`=0 and `frame_err`=0.
- R2: A falling edge on `rxd` starts a character only if the line is still low when sampled 8 ticks later. If the line has returned high by then, the event is discarded and nothing is stored.
- R3: With `msb_first`=0, the first data bit received is stored in bit 0 and the eighth in bit 7.
- R4: With `msb_first`=1, the first data bit received is stored in bit 7 and the eighth in bit 0.
- R5: A character whose stop bit has been sampled is placed in the FIFO without host action. Characters that follow each other with no idle time are all captured.
- R6: The FIFO holds up to 16 bytes and returns them in arrival order on `rd_data`. `level` counts 0..16, `empty` is set at 0 and `full` at 16.
- R7: A character completed while `full`=1 is discarded and the stored bytes are unchanged. `overrun` is then set and stays set until `ovr_clr` is pulsed.
- R8: `rd_en` while `empty`=1 changes neither `level` nor the flags.
- R9: A store and a `rd_en` in the same cycle, on a FIFO that is neither empty nor full, leave `level` unchanged.
- R10: A stop bit sampled low still stores the byte. It sets `frame_err`, which stays set until `ferr_clr` is pulsed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| os_tick | input | 1 | One-cycle pulse, 16 per bit period |
| rxd | input | 1 | Serial data line, idle high |
| msb_first | input | 1 | 1: first data bit lands in bit 7 |
| rd_en | input | 1 | Remove the oldest FIFO byte |
| ovr_clr | input | 1 | Clear the overrun flag |
| ferr_clr | input | 1 | Clear the framing-error flag |
| rd_data | output | 8 | Oldest stored byte (undefined when empty) |
| level | output | 5 | Number of stored bytes, 0..16 |
| empty | output | 1 | FIFO holds no bytes |
| full | output | 1 | FIFO holds 16 bytes |
| overrun | output | 1 | Sticky: a character was dropped |
| frame_err | output | 1 | Sticky: a stop bit was sampled low |

## Verification
The bench sends every byte value LSB-first and a spread of values MSB-first. A reversed bit order or an off-by-one sample point would show up as corrupted data. It fills the FIFO with sixteen back-to-back characters and then sends a seventeenth. A design that overwrote on full, or that lost characters between frames, would read back the wrong sequence or clear the overrun flag. It moves a single read strobe across every cycle of a stop bit, so one of those reads coincides with the store. A design that let one side win would end with a level of 0 or 2 instead of 1. It also sends a glitch shorter than half a bit, a low stop bit and a read on an empty FIFO. These catch a receiver that accepts false starts, drops bytes with bad stop bits, or lets pointers wrap when nothing is stored.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;
    typedef enum logic [1:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP
    } rx_state_e;
endpackage

// File: rtl/rx_deserializer.sv
module rx_deserializer
    import serial_rx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              os_tick,
    input  logic              rxd,
    input  logic              msb_first,
    output logic              byte_valid,
    output logic [DATA_W-1:0] byte_data,
    output logic              stop_bad
);
    localparam int CW = $clog2(OVS);
    localparam int IW = $clog2(DATA_W);

    typedef struct packed {
        rx_state_e         state;
        logic [CW-1:0]     cnt;
        logic [IW-1:0]     idx;
        logic [DATA_W-1:0] shreg;
        logic [1:0]        sync;
        logic              last;
        logic              valid;
        logic              bad;
        logic [DATA_W-1:0] data;
    } deser_t;

    deser_t s_q, s_d;
    logic   rx_s;
    logic   fall;

    assign rx_s = s_q.sync[1];
    assign fall = s_q.last & ~rx_s;

    always_comb begin
        s_d       = s_q;
        s_d.sync  = {s_q.sync[0], rxd};
        s_d.last  = rx_s;
        s_d.valid = 1'b0;
        s_d.bad   = 1'b0;
        unique case (s_q.state)
            RX_IDLE: begin
                if (fall) begin
                    s_d.state = RX_START;
                    s_d.cnt   = '0;
                end
            end
            RX_START: begin
                if (os_tick) begin
                    s_d.cnt = s_q.cnt + 1'b1;
                    if (s_q.cnt == CW'(OVS / 2 - 1)) begin
                        s_d.cnt   = '0;
                        s_d.idx   = '0;
                        s_d.state = rx_s ? RX_IDLE : RX_DATA;
                    end
                end
            end
            RX_DATA: begin
                if (os_tick) begin
                    s_d.cnt = s_q.cnt + 1'b1;
                    if (s_q.cnt == CW'(OVS - 1)) begin
                        s_d.cnt = '0;
                        if (msb_first)
                            s_d.shreg = {s_q.shreg[DATA_W-2:0], rx_s};
                        else
                            s_d.shreg = {rx_s, s_q.shreg[DATA_W-1:1]};
                        s_d.idx = s_q.idx + 1'b1;
                        if (s_q.idx == IW'(DATA_W - 1))
                            s_d.state = RX_STOP;
                    end
                end
            end
            RX_STOP: begin
                if (os_tick) begin
                    s_d.cnt = s_q.cnt + 1'b1;
                    if (s_q.cnt == CW'(OVS - 1)) begin
                        s_d.cnt   = '0;
                        s_d.valid = 1'b1;
                        s_d.bad   = ~rx_s;
                        s_d.data  = s_q.shreg;
                        s_d.state = RX_IDLE;
                    end
                end
            end
            default: s_d.state = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.state <= RX_IDLE;
            s_q.sync  <= 2'b11;
            s_q.last  <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign byte_valid = s_q.valid;
    assign byte_data  = s_q.data;
    assign stop_bad   = s_q.bad;
endmodule

// File: rtl/rx_byte_fifo.sv
module rx_byte_fifo #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] rd_data,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic              full,
    output logic              empty,
    output logic              dropped
);
    localparam int AW   = $clog2(DEPTH);
    localparam int CNTW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][DATA_W-1:0] mem;
        logic [AW-1:0]                wp;
        logic [AW-1:0]                rp;
        logic [CNTW-1:0]              cnt;
    } fifo_t;

    fifo_t f_q, f_d;
    logic  do_push;
    logic  do_pop;

    assign full    = (f_q.cnt == CNTW'(DEPTH));
    assign empty   = (f_q.cnt == '0);
    assign do_push = push & ~full;
    assign do_pop  = pop & ~empty;
    assign dropped = push & full;

    always_comb begin
        f_d = f_q;
        if (do_push) begin
            f_d.mem[f_q.wp] = push_data;
            f_d.wp = (f_q.wp == AW'(DEPTH - 1)) ? '0 : f_q.wp + 1'b1;
        end
        if (do_pop)
            f_d.rp = (f_q.rp == AW'(DEPTH - 1)) ? '0 : f_q.rp + 1'b1;
        if (do_push && !do_pop)
            f_d.cnt = f_q.cnt + 1'b1;
        else if (do_pop && !do_push)
            f_d.cnt = f_q.cnt - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    assign rd_data = f_q.mem[f_q.rp];
    assign count   = f_q.cnt;
endmodule

// File: rtl/serial_rx_fifo.sv
module serial_rx_fifo #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              os_tick,
    input  logic              rxd,
    input  logic              msb_first,
    input  logic              rd_en,
    input  logic              ovr_clr,
    input  logic              ferr_clr,
    output logic [DATA_W-1:0] rd_data,
    output logic [$clog2(DEPTH+1)-1:0] level,
    output logic              empty,
    output logic              full,
    output logic              overrun,
    output logic              frame_err
);
    typedef struct packed {
        logic ovr;
        logic ferr;
    } flags_t;

    flags_t            fl_q, fl_d;
    logic              byte_valid;
    logic [DATA_W-1:0] byte_data;
    logic              stop_bad;
    logic              dropped;

    rx_deserializer #(.DATA_W(DATA_W), .OVS(OVS)) u_deser (
        .clk        (clk),
        .rst_n      (rst_n),
        .os_tick    (os_tick),
        .rxd        (rxd),
        .msb_first  (msb_first),
        .byte_valid (byte_valid),
        .byte_data  (byte_data),
        .stop_bad   (stop_bad)
    );

    rx_byte_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (byte_valid),
        .push_data (byte_data),
        .pop       (rd_en),
        .rd_data   (rd_data),
        .count     (level),
        .full      (full),
        .empty     (empty),
        .dropped   (dropped)
    );

    always_comb begin
        fl_d.ovr  = dropped | (fl_q.ovr & ~ovr_clr);
        fl_d.ferr = (byte_valid & stop_bad) | (fl_q.ferr & ~ferr_clr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fl_q <= '0;
        else        fl_q <= fl_d;
    end

    assign overrun   = fl_q.ovr;
    assign frame_err = fl_q.ferr;
endmodule

// File: rtl/serial_rx_checker.sv
module serial_rx_checker #(
    parameter int DEPTH = 16,
    parameter int CNTW  = 5
) (
    input logic            clk,
    input logic            rst_n,
    input logic            byte_valid,
    input logic            rd_en,
    input logic            ovr_clr,
    input logic [CNTW-1:0] level,
    input logic            empty,
    input logic            full,
    input logic            overrun
);
    p_level_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        level <= CNTW'(DEPTH));

    p_drop_keeps_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid && full && !rd_en) |=> (level == CNTW'(DEPTH)));

    p_drop_sets_overrun_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid && full) |=> overrun);

    p_overrun_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !ovr_clr) |=> overrun);

    p_empty_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && empty && !byte_valid) |=> (level == '0));

    p_push_pop_level_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid && rd_en && !empty && !full) |=> $stable(level));

    p_store_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid |=> !byte_valid);
endmodule

bind serial_rx_fifo serial_rx_checker #(
    .DEPTH (DEPTH),
    .CNTW  ($clog2(DEPTH + 1))
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .byte_valid (byte_valid),
    .rd_en      (rd_en),
    .ovr_clr    (ovr_clr),
    .level      (level),
    .empty      (empty),
    .full       (full),
    .overrun    (overrun)
);

// File: tb/test_serial_rx_fifo.sv
module test_serial_rx_fifo;
    localparam int BIT_CLKS = 32;   // 16 ticks, one tick every 2 clocks

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       os_tick = 1'b0;
    logic       rxd = 1'b1;
    logic       msb_first = 1'b0;
    logic       rd_en = 1'b0;
    logic       ovr_clr = 1'b0;
    logic       ferr_clr = 1'b0;
    logic [7:0] rd_data;
    logic [4:0] level;
    logic       empty, full, overrun, frame_err;

    int errors = 0;
    int checks = 0;

    always #4 clk = ~clk;

    serial_rx_fifo i_serial_rx_fifo (
        .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rxd(rxd),
        .msb_first(msb_first), .rd_en(rd_en), .ovr_clr(ovr_clr),
        .ferr_clr(ferr_clr), .rd_data(rd_data), .level(level),
        .empty(empty), .full(full), .overrun(overrun), .frame_err(frame_err)
    );

    initial forever begin
        @(negedge clk);
        os_tick = ~os_tick;
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] bits, input logic stop_val);
        rxd = 1'b0;
        wait_clks(BIT_CLKS);
        for (int i = 0; i < 8; i++) begin
            rxd = bits[i];
            wait_clks(BIT_CLKS);
        end
        rxd = stop_val;
        wait_clks(BIT_CLKS);
        rxd = 1'b1;
    endtask

    task automatic pop_one;
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    function automatic logic [7:0] rev8(input logic [7:0] v);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = v[7-i];
        return r;
    endfunction

    initial begin
        wait_clks(190000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        wait_clks(3);
        // R1: reset state
        check("R1 empty", int'(empty), 1);
        check("R1 full", int'(full), 0);
        check("R1 level", int'(level), 0);
        check("R1 overrun", int'(overrun), 0);
        check("R1 frame_err", int'(frame_err), 0);
        rst_n = 1'b1;
        wait_clks(BIT_CLKS);

        // R8: read on empty
        pop_one();
        wait_clks(2);
        check("R8 level after empty read", int'(level), 0);
        check("R8 empty after empty read", int'(empty), 1);
        check("R8 overrun after empty read", int'(overrun), 0);

        // R2: false start shorter than half a bit
        rxd = 1'b0;
        wait_clks(8);
        rxd = 1'b1;
        wait_clks(BIT_CLKS * 11);
        check("R2 false start stores nothing", int'(level), 0);

        // R3/R5: all byte values LSB-first
        for (int v = 0; v < 256; v++) begin
            send_frame(8'(v), 1'b1);
            wait_clks(4);
            check("R5 level after frame", int'(level), 1);
            check("R3 lsb-first data", int'(rd_data), v);
            pop_one();
        end

        // R4: MSB-first
        msb_first = 1'b1;
        for (int v = 1; v < 256; v += 4) begin
            send_frame(8'(v), 1'b1);
            wait_clks(4);
            check("R4 msb-first data", int'(rd_data), int'(rev8(8'(v))));
            pop_one();
        end
        msb_first = 1'b0;

        // R10: low stop bit
        send_frame(8'h5A, 1'b0);
        wait_clks(4);
        check("R10 frame_err set", int'(frame_err), 1);
        check("R10 byte still stored", int'(rd_data), 'h5A);
        pop_one();
        wait_clks(BIT_CLKS);
        check("R10 frame_err sticky", int'(frame_err), 1);
        ferr_clr = 1'b1;
        @(negedge clk);
        ferr_clr = 1'b0;
        check("R10 frame_err cleared", int'(frame_err), 0);

        // R5/R6: sixteen back-to-back frames
        for (int k = 0; k < 16; k++) send_frame(8'(k * 13 + 7), 1'b1);
        wait_clks(4);
        check("R6 level full", int'(level), 16);
        check("R6 full flag", int'(full), 1);
        check("R7 no overrun yet", int'(overrun), 0);

        // R7: seventeenth frame dropped
        send_frame(8'hEE, 1'b1);
        wait_clks(4);
        check("R7 level stays 16", int'(level), 16);
        check("R7 overrun set", int'(overrun), 1);
        for (int k = 0; k < 16; k++) begin
            check("R6/R7 fifo order and contents", int'(rd_data), (k * 13 + 7) & 255);
            pop_one();
        end
        check("R6 empty after drain", int'(empty), 1);
        check("R7 overrun sticky", int'(overrun), 1);
        ovr_clr = 1'b1;
        @(negedge clk);
        ovr_clr = 1'b0;
        check("R7 overrun cleared", int'(overrun), 0);

        // R9: one read strobe swept across the stop bit, one byte pre-stored
        send_frame(8'h11, 1'b1);
        wait_clks(4);
        for (int k = 0; k < BIT_CLKS; k++) begin
            fork
                send_frame(8'(k + 64), 1'b1);
                begin
                    wait_clks(BIT_CLKS * 9 + k);
                    pop_one();
                end
            join
            wait_clks(4);
            check("R9 level after store plus read", int'(level), 1);
            check("R9 surviving byte", int'(rd_data), k + 64);
        end

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule